// File: doc/BRIEF.md
# Physical Address Region Decoder

This block sits between a processor's load/store path and the many targets behind it. A request carries a physical address, a size code, a read/write flag and up to 64 bits of write data. The block decides which single target the address reaches, drives that target's access port in the cycle of acceptance, and returns one response with the read data extended to 64 bits. The targets are the control-register space (store queues, eight cache and translation-buffer array ports, and register blocks), mirrored main RAM, and 4 KiB pages of peripheral registers. Addresses in the interleaved video window are rewritten before the page lookup.

Side effects come out as single-cycle strobes. A write into a video window invalidates the texture cache, and a video access invalidates the render buffer with a read/write flag. A write into the low protected area is dropped and answered with an error. A 64-bit access is carried out as two 32-bit accesses in consecutive cycles, low half first, and the block accepts nothing else in between.

Top module: `phys_region_router`

## Requirements
- R1: An address at or above 0xE0000000 is control space. If its bits 28:24 are 0 to 3, it selects the store queues (select code 1). If they are 0x10 to 0x17, it selects in rising order the instruction-cache address, instruction-cache data, instruction-TLB address, instruction-TLB data, operand-cache address, operand-cache data, unified-TLB address and unified-TLB data arrays (codes 2 to 9). These targets get the full address as offset.
- R2: Any other control-space address selects a register block (code 10), with index bits 28:19 and offset bits 11:0. Writes there are never dropped, even when the low 29 address bits are below 0x200000.
- R3: Outside control space, an address with (a & 0x1C000000) == 0x0C000000 selects main RAM (code 11), with offset a[23:0], so RAM repeats across the window.
- R4: An address with (a & 0x1F800000) == 0x04000000 is rewritten to ((a & 0x00FFFFF8) >> 1) | ((a & 4) << 20) | (a & 3) | 0x05000000. A write with (a & 0x1F800000) == 0x11000000 is rewritten the same way. The rewritten address is then looked up as a page.
- R5: A write that is not control space and not RAM, and whose (rewritten) address has low 29 bits below 0x200000, drives no target (code 0). Its response has rsp_err = 1 and zero data.
- R6: The response data is extended from the 32-bit target data. A byte (size 0) is sign-extended from bit 7 and a word (size 1) from bit 15, to 32 bits. A long (size 2) is taken as is. The upper 32 bits are then zero. Writes and errored responses carry zero data.
- R7: A write to either video window (mask 0x1F800000 equal to 0x04000000 or 0x11000000) pulses tex_inv_valid with tex_inv_addr = a & 0x7FFFFF, in the cycle of the access.
- R8: An access to window 0x04000000 or 0x05000000, or a write to window 0x11000000, pulses rb_inv_valid in the cycle of the access. rb_inv_addr is the rewritten address and rb_inv_write equals the write flag.
- R9: Remaining addresses select a peripheral page (code 12), with index bits 28:12 and offset bits 11:0. If the target reports tgt_unmapped for a page or register block access, the response has rsp_err = 1.
- R10: A quad (size 3) becomes two long accesses: first addr with wdata[31:0], then addr+4 with wdata[63:32]. The response data is {high result, low result}, and the error is the OR of both halves.
- R11: The response comes one cycle after acceptance, or two cycles after acceptance for a quad. req_ready is low in the cycle between the two halves of a quad.
- R12: While in reset, req_ready is 1 and rsp_valid and tgt_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Physical address |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 quad |
| req_write | input | 1 | 1 for write |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Extended read data |
| rsp_err | output | 1 | Dropped write or unmapped target |
| tgt_valid | output | 1 | Target access this cycle |
| tgt_sel | output | 4 | Target select code |
| tgt_index | output | 17 | Block or page index |
| tgt_offset | output | 32 | Offset within the target |
| tgt_write | output | 1 | Target write flag |
| tgt_size | output | 2 | Target access size |
| tgt_wdata | output | 32 | Target write data |
| tgt_rdata | input | 32 | Target read data, same cycle |
| tgt_unmapped | input | 1 | Selected block or page has no backing |
| tex_inv_valid | output | 1 | Texture-cache invalidate pulse |
| tex_inv_addr | output | 23 | Texture-cache invalidate address |
| rb_inv_valid | output | 1 | Render-buffer invalidate pulse |
| rb_inv_write | output | 1 | Render-buffer invalidate caused by a write |
| rb_inv_addr | output | 32 | Render-buffer invalidate address |

## Verification
The target port and both invalidate strobes are combinational from the request, so they are due in the cycle the request is accepted. The bench checks them one time unit after driving the inputs on the falling edge. The response is due one rising edge later for sizes 0 to 2, and two edges later for a quad. The bench keeps one pending expected response and compares it on the following falling edge, together with the next request's target outputs. It then checks the quad's second half, and the low req_ready between the halves, in the intermediate cycle.

// File: rtl/pard_pkg.sv
package pard_pkg;

  localparam int ADDR_W = 32;
  localparam int IDX_W  = 17;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;

  typedef enum logic [3:0] {
    T_NONE = 4'd0,
    T_SQ   = 4'd1,
    T_ICA  = 4'd2,
    T_ICD  = 4'd3,
    T_ITA  = 4'd4,
    T_ITD  = 4'd5,
    T_OCA  = 4'd6,
    T_OCD  = 4'd7,
    T_UTA  = 4'd8,
    T_UTD  = 4'd9,
    T_CREG = 4'd10,
    T_RAM  = 4'd11,
    T_PAGE = 4'd12
  } tgt_e;

  // bank-interleaved video window to linear window
  function automatic logic [ADDR_W-1:0] vid_interleave(input logic [ADDR_W-1:0] a);
    vid_interleave = ((a & 32'h00FF_FFF8) >> 1) | ((a & 32'h0000_0004) << 20)
                   | (a & 32'h0000_0003) | 32'h0500_0000;
  endfunction

endpackage

// File: rtl/pard_decode.sv
module pard_decode
  import pard_pkg::*;
#(
  parameter logic [31:0] CTRL_BASE = 32'hE000_0000,
  parameter logic [31:0] RAM_MASK  = 32'h1C00_0000,
  parameter logic [31:0] RAM_MATCH = 32'h0C00_0000,
  parameter int          RAM_OFS_W = 24,
  parameter int          REG_OFS_W = 12,
  parameter logic [31:0] RO_LIMIT  = 32'h0020_0000,
  parameter logic [31:0] WIN_MASK  = 32'h1F80_0000,
  parameter logic [31:0] VID_IL    = 32'h0400_0000,
  parameter logic [31:0] VID_LIN   = 32'h0500_0000,
  parameter logic [31:0] VID_ALT   = 32'h1100_0000
) (
  input  logic [31:0]      addr,
  input  logic             write,
  output tgt_e             sel,
  output logic [IDX_W-1:0] index,
  output logic [31:0]      offset,
  output logic             ro_drop,
  output logic             map_chk,
  output logic             tex_hit,
  output logic [22:0]      tex_addr,
  output logic             rb_hit,
  output logic [31:0]      rb_addr
);

  localparam int          PHYS_TOP  = 28;
  localparam int          BLK_LO    = 19;
  localparam logic [31:0] PHYS_MASK = 32'h1FFF_FFFF;

  logic        ctrl, ram_hit, vid_il, vid_lin, vid_alt, rewrite, ro_hit;
  logic [4:0]  sub;
  logic [31:0] eff;

  always_comb begin
    ctrl    = (addr >= CTRL_BASE);
    sub     = addr[PHYS_TOP:24];
    ram_hit = ((addr & RAM_MASK) == RAM_MATCH);
    vid_il  = ((addr & WIN_MASK) == VID_IL);
    vid_lin = ((addr & WIN_MASK) == VID_LIN);
    vid_alt = ((addr & WIN_MASK) == VID_ALT);
    rewrite = !ctrl && (vid_il || (write && vid_alt));
    eff     = rewrite ? vid_interleave(addr) : addr;
    ro_hit  = write && ((eff & PHYS_MASK) < RO_LIMIT);
  end

  always_comb begin
    sel     = T_NONE;
    index   = '0;
    offset  = '0;
    ro_drop = 1'b0;
    map_chk = 1'b0;
    if (ctrl) begin
      offset = addr;
      if (sub < 5'd4) begin
        sel = T_SQ;
      end else if (sub[4:3] == 2'b10) begin
        sel = tgt_e'(4'd2 + {1'b0, sub[2:0]});
      end else begin
        sel     = T_CREG;
        index   = IDX_W'(addr[PHYS_TOP:BLK_LO]);
        offset  = 32'(addr[REG_OFS_W-1:0]);
        map_chk = 1'b1;
      end
    end else if (ram_hit) begin
      sel    = T_RAM;
      offset = 32'(addr[RAM_OFS_W-1:0]);
    end else if (ro_hit) begin
      ro_drop = 1'b1;
    end else begin
      sel     = T_PAGE;
      index   = IDX_W'(eff[PHYS_TOP:REG_OFS_W]);
      offset  = 32'(eff[REG_OFS_W-1:0]);
      map_chk = 1'b1;
    end
  end

  assign tex_hit  = !ctrl && write && (vid_il || vid_alt);
  assign tex_addr = addr[22:0];
  assign rb_hit   = !ctrl && (vid_il || vid_lin || (write && vid_alt));
  assign rb_addr  = eff;

endmodule

// File: rtl/pard_extend.sv
module pard_extend
  import pard_pkg::*;
(
  input  logic [31:0] raw,
  input  size_e       size,
  output logic [63:0] ext
);

  logic [31:0] ext32;

  always_comb begin
    case (size)
      SZ_BYTE: ext32 = {{24{raw[7]}}, raw[7:0]};
      SZ_WORD: ext32 = {{16{raw[15]}}, raw[15:0]};
      default: ext32 = raw;
    endcase
    ext = {32'h0, ext32};
  end

endmodule

// File: rtl/pard_seq.sv
module pard_seq
  import pard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  size_e       req_size,
  input  logic        req_write,
  input  logic [63:0] req_wdata,
  input  logic [31:0] raw_data,
  input  logic [63:0] ext_data,
  input  logic        acc_err,
  output logic        cur_issue,
  output logic [31:0] cur_addr,
  output size_e       cur_size,
  output logic        cur_write,
  output logic [31:0] cur_wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        rsp_err
);

  typedef enum logic {S_IDLE = 1'b0, S_HI = 1'b1} st_e;

  st_e         state_q, state_d;
  logic [31:0] hi_addr_q, hi_wdata_q, lo_data_q;
  logic        hi_write_q, lo_err_q;
  logic        rsp_valid_q, rsp_valid_d, rsp_err_q, rsp_err_d;
  logic [63:0] rsp_rdata_q, rsp_rdata_d;
  logic        accept, is_quad, split_en, in_hi;

  always_comb begin
    in_hi     = (state_q == S_HI);
    req_ready = !in_hi;
    accept    = req_valid && req_ready;
    is_quad   = (req_size == SZ_QUAD);
    split_en  = accept && is_quad;
    cur_issue = accept || in_hi;
    cur_addr  = in_hi ? hi_addr_q : req_addr;
    cur_write = in_hi ? hi_write_q : req_write;
    cur_wdata = in_hi ? hi_wdata_q : req_wdata[31:0];
    cur_size  = (in_hi || is_quad) ? SZ_LONG : req_size;
  end

  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_err_d   = rsp_err_q;
    rsp_rdata_d = rsp_rdata_q;
    if (in_hi) begin
      state_d     = S_IDLE;
      rsp_valid_d = 1'b1;
      rsp_err_d   = lo_err_q || acc_err;
      rsp_rdata_d = (lo_err_q || acc_err || hi_write_q) ? 64'h0 : {raw_data, lo_data_q};
    end else if (split_en) begin
      state_d = S_HI;
    end else if (accept) begin
      rsp_valid_d = 1'b1;
      rsp_err_d   = acc_err;
      rsp_rdata_d = (acc_err || req_write) ? 64'h0 : ext_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_err_q   <= rsp_err_d;
        rsp_rdata_q <= rsp_rdata_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_addr_q  <= '0;
      hi_wdata_q <= '0;
      hi_write_q <= 1'b0;
      lo_data_q  <= '0;
      lo_err_q   <= 1'b0;
    end else if (split_en) begin
      hi_addr_q  <= req_addr + 32'd4;
      hi_wdata_q <= req_wdata[63:32];
      hi_write_q <= req_write;
      lo_data_q  <= raw_data;
      lo_err_q   <= acc_err;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  // R11: single access answered on the next cycle
  a_r11_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != SZ_QUAD) |=> rsp_valid);

  // R11: nothing taken and nothing answered between quad halves
  a_r11_quad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == SZ_QUAD) |=> (!req_ready && !rsp_valid));

  // R10: quad answered two cycles after acceptance
  a_r10_quad_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == SZ_QUAD) |=> ##1 rsp_valid);

  // R6: non-quad results have a zero upper half
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != SZ_QUAD) |=> (rsp_rdata[63:32] == 32'h0));

endmodule

// File: rtl/phys_region_router.sv
module phys_region_router
  import pard_pkg::*;
#(
  parameter int RAM_OFS_W = 24,
  parameter int REG_OFS_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [63:0] req_wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        rsp_err,
  output logic        tgt_valid,
  output logic [3:0]  tgt_sel,
  output logic [16:0] tgt_index,
  output logic [31:0] tgt_offset,
  output logic        tgt_write,
  output logic [1:0]  tgt_size,
  output logic [31:0] tgt_wdata,
  input  logic [31:0] tgt_rdata,
  input  logic        tgt_unmapped,
  output logic        tex_inv_valid,
  output logic [22:0] tex_inv_addr,
  output logic        rb_inv_valid,
  output logic        rb_inv_write,
  output logic [31:0] rb_inv_addr
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             cur_issue, cur_write, ro_drop, map_chk, tex_hit, rb_hit, acc_err;
  logic [31:0]      cur_addr, cur_wdata, offset, rb_addr;
  size_e            cur_size;
  tgt_e             sel;
  logic [IDX_W-1:0] index;
  logic [22:0]      tex_addr;
  logic [63:0]      ext_data;

  pard_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (size_e'(req_size)),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .raw_data  (tgt_rdata),
    .ext_data  (ext_data),
    .acc_err   (acc_err),
    .cur_issue (cur_issue),
    .cur_addr  (cur_addr),
    .cur_size  (cur_size),
    .cur_write (cur_write),
    .cur_wdata (cur_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  pard_decode #(
    .RAM_OFS_W (RAM_OFS_W),
    .REG_OFS_W (REG_OFS_W)
  ) u_decode (
    .addr     (cur_addr),
    .write    (cur_write),
    .sel      (sel),
    .index    (index),
    .offset   (offset),
    .ro_drop  (ro_drop),
    .map_chk  (map_chk),
    .tex_hit  (tex_hit),
    .tex_addr (tex_addr),
    .rb_hit   (rb_hit),
    .rb_addr  (rb_addr)
  );

  pard_extend u_extend (
    .raw  (tgt_rdata),
    .size (cur_size),
    .ext  (ext_data)
  );

  always_comb begin
    acc_err       = ro_drop || (map_chk && tgt_unmapped);
    tgt_valid     = cur_issue && (sel != T_NONE);
    tgt_sel       = sel;
    tgt_index     = index;
    tgt_offset    = offset;
    tgt_write     = cur_write;
    tgt_size      = cur_size;
    tgt_wdata     = cur_wdata;
    tex_inv_valid = cur_issue && tex_hit;
    tex_inv_addr  = tex_addr;
    rb_inv_valid  = cur_issue && rb_hit;
    rb_inv_write  = cur_write;
    rb_inv_addr   = rb_addr;
  end

  // R5: an accepted single write that reaches no target is answered with an error
  a_r5_drop_err: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_ready && req_size != 2'd3 && req_write && !tgt_valid) |=> rsp_err);

  // R7: texture invalidates accompany write accesses only
  a_r7_tex_on_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    tex_inv_valid |-> (tgt_valid && tgt_write));

  // R8: render-buffer invalidates accompany a real target access
  a_r8_rb_with_access: assert property (@(posedge clk) disable iff (!rst_int_n)
    rb_inv_valid |-> tgt_valid);

endmodule

// File: tb/test_phys_region_router.sv
module test_phys_region_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        tgt_valid, tgt_write, tgt_unmapped;
  logic [3:0]  tgt_sel;
  logic [16:0] tgt_index;
  logic [31:0] tgt_offset, tgt_wdata, tgt_rdata;
  logic [1:0]  tgt_size;
  logic        tex_inv_valid, rb_inv_valid, rb_inv_write;
  logic [22:0] tex_inv_addr;
  logic [31:0] rb_inv_addr;

  always #4 clk = ~clk;

  // target model: data derived from select and offset, page index ending in F unmapped
  assign tgt_rdata    = tgt_offset ^ 32'h8F80_80F0 ^ {28'h0, tgt_sel};
  assign tgt_unmapped = ((tgt_sel == 4'd10) || (tgt_sel == 4'd12)) && (tgt_index[3:0] == 4'hF);

  phys_region_router i_phys_region_router (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .req_size (req_size), .req_write (req_write), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err),
    .tgt_valid (tgt_valid), .tgt_sel (tgt_sel), .tgt_index (tgt_index),
    .tgt_offset (tgt_offset), .tgt_write (tgt_write), .tgt_size (tgt_size),
    .tgt_wdata (tgt_wdata), .tgt_rdata (tgt_rdata), .tgt_unmapped (tgt_unmapped),
    .tex_inv_valid (tex_inv_valid), .tex_inv_addr (tex_inv_addr),
    .rb_inv_valid (rb_inv_valid), .rb_inv_write (rb_inv_write), .rb_inv_addr (rb_inv_addr)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit          pend = 0;
  logic [63:0] pend_data;
  bit          pend_err;
  string       pend_tag;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of the address map
  task automatic ref_route(input logic [31:0] a, input bit w,
                           output int sel, output logic [16:0] idx, output logic [31:0] ofs,
                           output bit ro, output bit tv, output logic [22:0] ta,
                           output bit rv, output logic [31:0] ra);
    logic [31:0] e;
    int f;
    bit v4, v5, v11, ctl;
    ctl = (a >= 32'hE000_0000);
    v4  = ((a & 32'h1F80_0000) == 32'h0400_0000);
    v5  = ((a & 32'h1F80_0000) == 32'h0500_0000);
    v11 = ((a & 32'h1F80_0000) == 32'h1100_0000);
    e = a;
    if (!ctl && (v4 || (w && v11)))
      e = ((a & 32'h00FF_FFF8) >> 1) | ((a & 32'h4) << 20) | (a & 32'h3) | 32'h0500_0000;
    sel = 0; idx = '0; ofs = '0; ro = 0;
    if (ctl) begin
      f = int'(a[28:24]);
      ofs = a;
      if (f < 4) sel = 1;
      else if (f >= 16 && f <= 23) sel = f - 14;
      else begin sel = 10; idx = 17'(a[28:19]); ofs = {20'h0, a[11:0]}; end
    end else if ((a & 32'h1C00_0000) == 32'h0C00_0000) begin
      sel = 11; ofs = {8'h0, a[23:0]};
    end else if (w && ((e & 32'h1FFF_FFFF) < 32'h0020_0000)) begin
      ro = 1;
    end else begin
      sel = 12; idx = e[28:12]; ofs = {20'h0, e[11:0]};
    end
    tv = !ctl && w && (v4 || v11);
    ta = a[22:0];
    rv = !ctl && (v4 || v5 || (w && v11));
    ra = e;
  endtask

  // compare the combinational target side; return expected raw data and error
  task automatic check_access(input logic [31:0] a, input bit w, input logic [1:0] sz,
                              input logic [31:0] wd, input string tag,
                              output logic [31:0] raw, output bit err);
    int sel; logic [16:0] idx; logic [31:0] ofs, ra; bit ro, tv, rv; logic [22:0] ta;
    ref_route(a, w, sel, idx, ofs, ro, tv, ta, rv, ra);
    chk(tgt_valid == (sel != 0), {tag, " tgt_valid"}, 64'(tgt_valid), 64'(sel != 0));
    chk(tgt_sel == 4'(sel), {tag, " tgt_sel"}, 64'(tgt_sel), 64'(sel));
    if (sel != 0) begin
      chk(tgt_index == idx && tgt_offset == ofs, {tag, " index/offset"},
          {15'h0, tgt_index, tgt_offset}, {15'h0, idx, ofs});
      chk(tgt_write == w && tgt_size == sz, {tag, " write/size"},
          64'({tgt_write, tgt_size}), 64'({w, sz}));
      if (w) chk(tgt_wdata == wd, {tag, " wdata"}, 64'(tgt_wdata), 64'(wd));
    end
    chk(tex_inv_valid == tv, {tag, " R7 tex_inv_valid"}, 64'(tex_inv_valid), 64'(tv));
    if (tv) chk(tex_inv_addr == ta, {tag, " R7 tex_inv_addr"}, 64'(tex_inv_addr), 64'(ta));
    chk(rb_inv_valid == rv, {tag, " R8 rb_inv_valid"}, 64'(rb_inv_valid), 64'(rv));
    if (rv) chk(rb_inv_addr == ra && rb_inv_write == w, {tag, " R8 rb addr/write"},
                {31'h0, rb_inv_write, rb_inv_addr}, {31'h0, w, ra});
    raw = ofs ^ 32'h8F80_80F0 ^ 32'(sel);
    err = ro || (((sel == 10) || (sel == 12)) && (idx[3:0] == 4'hF));
  endtask

  task automatic check_pending();
    if (pend) begin
      chk(rsp_valid == 1'b1, {pend_tag, " R11 rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk(rsp_rdata == pend_data, {pend_tag, " rsp_rdata"}, rsp_rdata, pend_data);
      chk(rsp_err == pend_err, {pend_tag, " rsp_err"}, 64'(rsp_err), 64'(pend_err));
      pend = 0;
    end else begin
      chk(rsp_valid == 1'b0, "R11 no spurious rsp_valid", 64'(rsp_valid), 64'd0);
    end
  endtask

  function automatic logic [63:0] extend(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return {32'h0, {24{d[7]}}, d[7:0]};
    if (sz == 2'd1) return {32'h0, {16{d[15]}}, d[15:0]};
    return {32'h0, d};
  endfunction

  // called at a falling edge; leaves the bench at a later falling edge
  task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input bit w,
                        input logic [63:0] wd, input string tag);
    logic [31:0] lo, hi; bit elo, ehi;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w; req_wdata = wd;
    #1;
    check_pending();
    chk(req_ready == 1'b1, {tag, " R11 ready"}, 64'(req_ready), 64'd1);
    check_access(a, w, (sz == 2'd3) ? 2'd2 : sz, wd[31:0], tag, lo, elo);
    @(negedge clk);
    if (sz == 2'd3) begin
      req_valid = 1'b0;
      #1;
      chk(req_ready == 1'b0, {tag, " R11 ready low mid-quad"}, 64'(req_ready), 64'd0);
      chk(rsp_valid == 1'b0, {tag, " R11 no rsp mid-quad"}, 64'(rsp_valid), 64'd0);
      check_access(a + 32'd4, w, 2'd2, wd[63:32], {tag, " R10 high half"}, hi, ehi);
      pend_err  = elo || ehi;
      pend_data = (pend_err || w) ? 64'h0 : {hi, lo};
      @(negedge clk);
    end else begin
      pend_err  = elo;
      pend_data = (elo || w) ? 64'h0 : extend(lo, sz);
    end
    pend = 1; pend_tag = tag;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    #1;
    check_pending();
    chk(tgt_valid == 1'b0, "idle tgt_valid", 64'(tgt_valid), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R12 reset ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(tgt_valid == 1'b0, "R12 reset tgt_valid", 64'(tgt_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: RAM and its mirrors, with R6 extension sizes
    do_req(32'h0C00_1234, 2'd2, 1'b0, 64'h0, "R3 ram long");
    do_req(32'h0D00_1234, 2'd0, 1'b0, 64'h0, "R3 R6 ram mirror byte");
    do_req(32'h8F00_12C0, 2'd0, 1'b0, 64'h0, "R3 R6 ram byte positive");
    do_req(32'h0C00_1234, 2'd1, 1'b0, 64'h0, "R6 ram word");
    do_req(32'h0C00_0070, 2'd1, 1'b1, 64'h0000_0000_0000_BEEF, "R3 ram word write");
    // R1: control space sub-decode
    do_req(32'hE000_0020, 2'd2, 1'b0, 64'h0, "R1 store queue");
    do_req(32'hF000_0000, 2'd2, 1'b0, 64'h0, "R1 icache address array");
    do_req(32'hF300_0008, 2'd2, 1'b1, 64'h0000_0000_1122_3344, "R1 itlb data array");
    do_req(32'hF700_0004, 2'd2, 1'b0, 64'h0, "R1 utlb data array");
    // R2: register blocks, never dropped
    do_req(32'hFF00_0010, 2'd2, 1'b0, 64'h0, "R2 register block");
    do_req(32'hE000_0000, 2'd2, 1'b1, 64'h0000_0000_CAFE_0001, "R2 R1 low control write kept");
    do_req(32'hE500_0000, 2'd1, 1'b1, 64'h0000_0000_0000_5A5A, "R2 control write low bits kept");
    do_req(32'hFC78_0000, 2'd2, 1'b0, 64'h0, "R2 R9 unmapped register block");
    idle();
    // R4/R8: video window reads
    do_req(32'h0400_0010, 2'd2, 1'b0, 64'h0, "R4 R8 video read even");
    do_req(32'h0400_0017, 2'd0, 1'b0, 64'h0, "R4 R8 video read odd");
    do_req(32'h0500_0100, 2'd2, 1'b0, 64'h0, "R8 linear video read");
    do_req(32'h1100_0040, 2'd2, 1'b0, 64'h0, "R8 alt window read no effect");
    // R7: video writes
    do_req(32'h0400_0014, 2'd2, 1'b1, 64'h0000_0000_0BAD_F00D, "R7 R4 video write");
    do_req(32'h1100_0040, 2'd2, 1'b1, 64'h0000_0000_1234_5678, "R7 R4 alt window write");
    do_req(32'h0500_0200, 2'd0, 1'b1, 64'h0000_0000_0000_00AA, "R8 linear video write");
    // R5: protected area
    do_req(32'h0000_1000, 2'd2, 1'b1, 64'h0000_0000_DEAD_BEEF, "R5 protected write");
    do_req(32'hA01F_FFFC, 2'd2, 1'b1, 64'h0000_0000_DEAD_BEEF, "R5 protected write high bits");
    do_req(32'h0000_1000, 2'd2, 1'b0, 64'h0, "R5 R9 protected read allowed");
    do_req(32'h0020_0000, 2'd2, 1'b1, 64'h0000_0000_0000_0001, "R5 boundary write kept");
    // R9: pages
    do_req(32'h0080_F000, 2'd2, 1'b0, 64'h0, "R9 unmapped page");
    do_req(32'h0081_2344, 2'd1, 1'b0, 64'h0, "R9 mapped page word");
    idle();
    // R10: quad split
    do_req(32'h0C00_0100, 2'd3, 1'b0, 64'h0, "R10 quad read ram");
    do_req(32'h0C00_0200, 2'd3, 1'b1, 64'h1111_2222_3333_4444, "R10 quad write ram");
    do_req(32'h0080_EFFC, 2'd3, 1'b0, 64'h0, "R10 R9 quad high half unmapped");
    do_req(32'h0400_0010, 2'd3, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, "R10 R7 quad video write");
    do_req(32'h0C00_0300, 2'd2, 1'b0, 64'h0, "R11 after quad");
    idle();
    idle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule